// File: doc/BRIEF.md
# Boot Alias Address Remap Decoder

This block decodes every processor bus address to one of three memories: the on-chip boot ROM, the on-chip SRAM0, or the external NOR flash. The processor fetches its reset and exception vectors from address zero, so a low window starting at zero is aliased onto one of these memories. Which memory it is depends on a boot-mode strap, captured as reset ends, and on a remap bit that software can write.

After reset the zero window shows non-volatile memory. With the strap high it shows the boot ROM; with the strap low it shows the NOR flash. Firmware copies its vector table into SRAM0 and then sets the remap bit. From then on SRAM0 answers at zero, and the flash can be reached only at its native base. The alias window is as large as the memory it shows: 2 MB for flash, 64 KB for ROM or SRAM. Inside that window the alias wins over any native region it covers. Addresses that hit no region raise a decode-error flag.

Top module: `boot_remap_decoder`

## Requirements
- R1: While reset is held and on the first cycle after it, the remap bit is 0 and `reg_rdata` reads 0.
- R2: The strap is captured on every clock edge while `rst_n` is low. After `rst_n` goes high the captured value is held, and strap changes have no effect on the decode until the next reset.
- R3: With the captured strap 1 and remap 0, valid addresses 0x0000_0000 to 0x0000_FFFF assert `sel_rom`.
- R4: With the captured strap 0 and remap 0, valid addresses 0x0000_0000 to 0x001F_FFFF assert `sel_flash`. This includes 0x0010_0000, where flash wins over the ROM native region.
- R5: With remap 1, valid addresses 0x0000_0000 to 0x0000_FFFF assert `sel_sram` for either strap value.
- R6: Addresses 0x1000_0000 to 0x101F_FFFF always assert `sel_flash`. Addresses 0x0020_0000 to 0x0020_FFFF always assert `sel_sram`. Addresses 0x0010_0000 to 0x0010_FFFF assert `sel_rom` when they lie outside the current alias window.
- R7: A valid address that hits neither the alias window nor any native region asserts `dec_err` in that same cycle, with all selects low.
- R8: For a valid access exactly one of `sel_rom`, `sel_sram`, `sel_flash`, `dec_err` is high. With `bus_valid` low all four are low.
- R9: When `reg_wr` is high at a clock edge, `reg_wdata` is stored as the remap bit; writing 0 clears it. From the next cycle the bit reads back on `reg_rdata` and steers the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_strap | input | 1 | Boot-mode strap: 1 = ROM at zero, 0 = flash at zero |
| bus_valid | input | 1 | Bus access present |
| bus_addr | input | 32 | Bus byte address |
| reg_wr | input | 1 | Remap register write strobe |
| reg_wdata | input | 1 | Remap bit value to write |
| reg_rdata | output | 1 | Current remap bit |
| sel_rom | output | 1 | Boot ROM select |
| sel_sram | output | 1 | SRAM0 select |
| sel_flash | output | 1 | NOR flash select |
| dec_err | output | 1 | Unmapped address |

## Verification
The selects and the error flag are combinational. They are due in the same cycle as the address, so the bench applies each address just after a falling edge and compares a moment later, before the next rising edge. A register write or a reset edge changes the state at the rising edge. Its effect on `reg_rdata` and on the decode therefore appears one cycle later, and the bench model updates its remap and strap copies only after that same edge. Strap toggles after reset and address sweeps across both ends of every window are compared in each cycle against the model.

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder #(
  parameter int              AW         = 32,
  parameter logic [AW-1:0]   ROM_BASE   = 32'h0010_0000,
  parameter int              ROM_LOG2   = 16,
  parameter logic [AW-1:0]   SRAM_BASE  = 32'h0020_0000,
  parameter int              SRAM_LOG2  = 16,
  parameter logic [AW-1:0]   FLASH_BASE = 32'h1000_0000,
  parameter int              FLASH_LOG2 = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_strap,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          reg_wr,
  input  logic          reg_wdata,
  output logic          reg_rdata,
  output logic          sel_rom,
  output logic          sel_sram,
  output logic          sel_flash,
  output logic          dec_err
);

  logic boot_q, remap_q;
  logic rom_d, sram_d, flash_d, err_d, zero_hit;
  int   alias_lg;

  function automatic logic in_region(input logic [AW-1:0] a, input logic [AW-1:0] base, input int lg);
    return (a >> lg) == (base >> lg);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q  <= boot_strap;
      remap_q <= 1'b0;
    end else if (reg_wr) begin
      remap_q <= reg_wdata;
    end
  end

  assign reg_rdata = remap_q;
  assign alias_lg  = remap_q ? SRAM_LOG2 : (boot_q ? ROM_LOG2 : FLASH_LOG2);
  assign zero_hit  = (bus_addr >> alias_lg) == '0;

  always_comb begin
    rom_d = 1'b0; sram_d = 1'b0; flash_d = 1'b0; err_d = 1'b0;
    if (zero_hit) begin
      if (remap_q)     sram_d  = 1'b1;
      else if (boot_q) rom_d   = 1'b1;
      else             flash_d = 1'b1;
    end else if (in_region(bus_addr, FLASH_BASE, FLASH_LOG2)) flash_d = 1'b1;
    else if (in_region(bus_addr, SRAM_BASE, SRAM_LOG2))       sram_d  = 1'b1;
    else if (in_region(bus_addr, ROM_BASE, ROM_LOG2))         rom_d   = 1'b1;
    else                                                      err_d   = 1'b1;
  end

  assign sel_rom   = bus_valid & rom_d;
  assign sel_sram  = bus_valid & sram_d;
  assign sel_flash = bus_valid & flash_d;
  assign dec_err   = bus_valid & err_d;

  // R8
  a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $onehot({sel_rom, sel_sram, sel_flash, dec_err}));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> ({sel_rom, sel_sram, sel_flash, dec_err} == 4'b0));
  // R9
  a_r9_write_back: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata == $past(reg_wdata)));
  // R2
  a_r2_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(boot_q));
  // R5
  a_r5_sram_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && reg_rdata && bus_addr == '0) |-> sel_sram);
  // R6
  a_r6_flash_native: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr[AW-1:FLASH_LOG2] == FLASH_BASE[AW-1:FLASH_LOG2]) |-> sel_flash);

endmodule

// File: tb/sim_boot_remap_decoder.sv
module sim_boot_remap_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, boot_strap = 1, bus_valid = 0, reg_wr = 0, reg_wdata = 0;
  logic [31:0] bus_addr = 0;
  logic reg_rdata, sel_rom, sel_sram, sel_flash, dec_err;

  int compared = 0, mismatched = 0;
  bit m_known = 0, m_boot = 0, m_remap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_remap_decoder u0 (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sel_rom(sel_rom), .sel_sram(sel_sram), .sel_flash(sel_flash), .dec_err(dec_err));

  // encoding {err, flash, sram, rom}
  function automatic logic [3:0] ref_dec(longint a, bit v, bit bt, bit rm);
    longint zlim;
    if (!v) return 4'b0000;
    zlim = rm ? 64'h1_0000 : (bt ? 64'h1_0000 : 64'h20_0000);
    if (a < zlim) return rm ? 4'b0010 : (bt ? 4'b0001 : 4'b0100);
    if (a >= 64'h1000_0000 && a < 64'h1020_0000) return 4'b0100;
    if (a >= 64'h0020_0000 && a < 64'h0021_0000) return 4'b0010;
    if (a >= 64'h0010_0000 && a < 64'h0011_0000) return 4'b0001;
    return 4'b1000;
  endfunction

  task automatic cyc(string tag, bit rn, bit st, bit v, logic [31:0] a, bit w, bit wd);
    logic [3:0] exp_v, act_v;
    @(negedge clk);
    rst_n = rn; boot_strap = st; bus_valid = v; bus_addr = a; reg_wr = w; reg_wdata = wd;
    #1;
    if (m_known) begin
      exp_v = ref_dec(longint'(a), v, m_boot, m_remap);
      act_v = {dec_err, sel_flash, sel_sram, sel_rom};
      compared++;
      if (act_v !== exp_v || reg_rdata !== m_remap) begin
        mismatched++;
        $display("FAIL %s addr=%h act sel=%b rd=%b exp sel=%b rd=%b", tag, a, act_v, reg_rdata, exp_v, m_remap);
      end
    end
    @(posedge clk);
    m_known = 1;
    if (!rn) begin m_boot = st; m_remap = 0; end
    else if (w) m_remap = wd;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset with strap high
    cyc("R1", 0, 1, 0, 0, 0, 0);
    cyc("R1", 0, 1, 1, 32'h0, 0, 0);
    cyc("R1", 1, 1, 1, 32'h0, 0, 0);
    // R2: strap toggles after reset, ROM still at zero
    cyc("R2", 1, 0, 1, 32'h0, 0, 0);
    cyc("R2", 1, 0, 1, 32'h0000_FFFC, 0, 0);
    // R3 / R7 window ends
    cyc("R3", 1, 1, 1, 32'h0000_0020, 0, 0);
    cyc("R7", 1, 0, 1, 32'h0001_0000, 0, 0);
    cyc("R7", 1, 0, 1, 32'h000F_FFFF, 0, 0);
    cyc("R6", 1, 0, 1, 32'h0010_0000, 0, 0);
    cyc("R6", 1, 0, 1, 32'h0010_FFFF, 0, 0);
    cyc("R7", 1, 0, 1, 32'h0011_0000, 0, 0);
    cyc("R6", 1, 0, 1, 32'h0020_0000, 0, 0);
    cyc("R6", 1, 0, 1, 32'h0020_FFFF, 0, 0);
    cyc("R7", 1, 0, 1, 32'h0021_0000, 0, 0);
    cyc("R6", 1, 0, 1, 32'h1000_0000, 0, 0);
    cyc("R6", 1, 0, 1, 32'h101F_FFFF, 0, 0);
    cyc("R7", 1, 0, 1, 32'h1020_0000, 0, 0);
    cyc("R7", 1, 0, 1, 32'hFFFF_FFFF, 0, 0);
    cyc("R8", 1, 0, 0, 32'h0020_0000, 0, 0);
    // R9 / R5: set remap
    cyc("R9", 1, 0, 1, 32'h0, 1, 1);
    cyc("R5", 1, 0, 1, 32'h0, 0, 0);
    cyc("R5", 1, 1, 1, 32'h0000_FFFF, 0, 0);
    cyc("R7", 1, 0, 1, 32'h0001_0000, 0, 0);
    cyc("R6", 1, 0, 1, 32'h0010_0004, 0, 0);
    cyc("R6", 1, 0, 1, 32'h1000_0000, 0, 0);
    cyc("R9", 1, 0, 1, 32'h0, 1, 0);
    cyc("R9", 1, 0, 1, 32'h0, 0, 0);
    // R2 / R4: reset again with strap low
    cyc("R1", 0, 0, 1, 32'h0, 1, 1);
    cyc("R1", 0, 0, 1, 32'h0, 0, 0);
    cyc("R1", 1, 0, 1, 32'h0, 0, 0);
    cyc("R2", 1, 1, 1, 32'h0, 0, 0);
    cyc("R4", 1, 1, 1, 32'h0010_0000, 0, 0);
    cyc("R4", 1, 0, 1, 32'h001F_FFFF, 0, 0);
    cyc("R6", 1, 0, 1, 32'h0020_0000, 0, 0);
    cyc("R8", 1, 0, 0, 32'h0, 0, 0);
    cyc("R9", 1, 0, 1, 32'h0010_0000, 1, 1);
    cyc("R5", 1, 0, 1, 32'h0000_0004, 0, 0);
    cyc("R6", 1, 0, 1, 32'h0010_0000, 0, 0);
    cyc("R7", 1, 0, 1, 32'h001F_FFFF, 0, 0);
    for (int i = 0; i < 32; i++)
      cyc("R8", 1, i[0], i[1], 32'h0000_8000 << (i % 16), i[4] & i[2], i[3]);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule